// File: doc/BRIEF.md
# Pseudo-DMA Block Staging Buffer

This block sits between a host-side byte data port and the data phase of a SCSI bus. It stages transfers through a single-port buffer of up to 512 bytes. The host and the bus side take turns on that buffer, one whole block at a time. A ready flag and the host position decide whose turn it is.

In send mode the host fills the block first. The buffer then drains to the bus one byte at a time, each byte with a REQ/ACK handshake. In initiator-receive mode the order is reversed: the bus fills the block and the host then reads it out. A transfer is started with a total length. The block size and the number of blocks both come from that length. When the last block has been moved, the block raises end of DMA, optionally raises an interrupt, and returns to idle.

Top module: `pdma_buf`

## Requirements
- R1: After reset the outputs ready, loaded, end_of_dma, last_byte_sent, irq, dma_active and scsi_ack are all 0. A host read while idle returns 0xFF on host_rdata in the cycle after host_rd.
- R2: A start with xfer_len = 0 is ignored. Otherwise the block size is min(512, xfer_len). The block count is xfer_len >> 9, or 1 when xfer_len < 512. Only count × size bytes move on the bus.
- R3: start_send sets ready and loaded, clears end_of_dma, last_byte_sent and irq, and sets the host position to 0. Each host write stores host_wdata at the host position and advances it, but only while the position is below the block size. Bytes leave on the bus in write order, and writes at any other time are ignored.
- R4: start_recv sets ready and loaded and sets the host position to the block size. Host reads therefore return 0xFF until the bus has filled the block. After that, reads return the bus bytes in arrival order.
- R5: ready clears in the cycle after the host access that brings the host position up to the block size. It is set again one cycle later if the block is still loaded and blocks remain.
- R6: The bus side runs only when ready is set, a block is loaded and the host position equals the block size. For each byte it waits for scsi_req, then holds scsi_ack high for exactly one cycle with the byte on scsi_dout, then drops it. With scsi_req held high, the first ACK appears 4 cycles after the cycle in which the final host write is taken.
- R7: If scsi_req stays low for 10 polling cycles, the byte is transferred anyway. With scsi_req held low, the first ACK appears 13 cycles after the final host write.
- R8: After a full block on the bus, the host position returns to 0 and the block counter decrements modulo 256. If blocks remain, loaded stays 1, end_of_dma stays 0, and the next block begins with a host phase.
- R9: When the counter reaches zero, loaded clears and end_of_dma sets. last_byte_sent sets only in send mode. irq sets only when eop_irq_en is 1.
- R10: After the final send block the block is idle and host writes cause no bus activity. After the final receive block the host reads that block out, and the block then goes idle and returns 0xFF.
- R11: When busy_mon_en is 1 and scsi_bsy is low during a transfer, the transfer is cancelled in the next cycle: dma_active, loaded and ready go to 0. Later host writes cause no bus activity. With busy_mon_en at 0, a low scsi_bsy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_send | input | 1 | Pulse: begin a send transfer |
| start_recv | input | 1 | Pulse: begin a receive transfer (start_send wins if both) |
| xfer_len | input | 16 | Total transfer length in bytes, sampled at start |
| eop_irq_en | input | 1 | Allow irq at end of transfer |
| busy_mon_en | input | 1 | Cancel transfer when scsi_bsy drops |
| host_wr | input | 1 | Host data port write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data port read strobe |
| host_rdata | output | 8 | Read byte, valid the cycle after host_rd |
| scsi_req | input | 1 | Target REQ |
| scsi_bsy | input | 1 | Bus BSY |
| scsi_din | input | 8 | Bus data from target |
| scsi_ack | output | 1 | Initiator ACK |
| scsi_dout | output | 8 | Bus data to target |
| ready | output | 1 | Ready flag |
| loaded | output | 1 | Block loaded flag |
| end_of_dma | output | 1 | Transfer complete |
| last_byte_sent | output | 1 | Send transfer complete |
| irq | output | 1 | End-of-process interrupt |
| dma_active | output | 1 | A transfer mode is active |

## Verification
A wrong host position appears as missing or extra ACK pulses, or as bytes on scsi_dout out of write order, within a single block. A wrong ready or loaded flag shows up either as ACKs during the host phase or as a stall that never produces the first ACK. Both are visible within a few cycles of the final host access. A wrong block counter appears at the end of the transfer: end_of_dma rises one block early or late, or the second block of a two-block transfer is skipped.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 9;
    localparam int unsigned BLK_BYTES = 1 << ADDR_W;
    localparam int unsigned POS_W     = ADDR_W + 1;
    localparam int unsigned LEN_W     = 16;
    localparam int unsigned CNT_W     = 8;

    typedef enum logic [1:0] {XM_IDLE, XM_SEND, XM_RECV} xfer_mode_e;
    typedef enum logic [2:0] {BE_IDLE, BE_FETCH, BE_WAIT, BE_ACK, BE_REL} bus_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ram_req_t;

    function automatic logic [POS_W-1:0] calc_blk(input logic [LEN_W-1:0] len);
        if (len >= LEN_W'(BLK_BYTES)) return POS_W'(BLK_BYTES);
        return POS_W'(len);
    endfunction

    function automatic logic [CNT_W-1:0] calc_cnt(input logic [LEN_W-1:0] len);
        if (len < LEN_W'(BLK_BYTES)) return CNT_W'(1);
        return CNT_W'(len >> ADDR_W);
    endfunction
endpackage

// File: rtl/pdma_ram.sv
module pdma_ram
    import pdma_pkg::*;
(
    input  logic              clk,
    input  ram_req_t          req,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mem [BLK_BYTES];

    always_ff @(posedge clk) begin
        if (req.we) mem[req.addr] <= req.wdata;
        q <= mem[req.addr];
    end
endmodule

// File: rtl/pdma_bus_eng.sv
module pdma_bus_eng
    import pdma_pkg::*;
#(
    parameter int unsigned REQ_TIMEOUT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              go,
    input  logic              dir_send,
    input  logic [POS_W-1:0]  blk_len,
    input  logic              scsi_req,
    input  logic [DATA_W-1:0] scsi_din,
    input  logic [DATA_W-1:0] ram_q,
    output ram_req_t          ram_req,
    output logic              busy,
    output logic              blk_done,
    output logic              scsi_ack,
    output logic [DATA_W-1:0] scsi_dout
);
    localparam int unsigned TMR_W = $clog2(REQ_TIMEOUT + 1);

    bus_state_e        state;
    logic [POS_W-1:0]  pos;
    logic [TMR_W-1:0]  tmr;
    logic [DATA_W-1:0] data_q;
    logic              last_byte;

    assign last_byte = (pos == blk_len - POS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state  <= BE_IDLE;
            pos    <= '0;
            tmr    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                BE_IDLE: begin
                    if (go) begin
                        state <= BE_FETCH;
                        pos   <= '0;
                    end
                end
                BE_FETCH: begin
                    state <= BE_WAIT;
                    tmr   <= '0;
                end
                BE_WAIT: begin
                    if (scsi_req || (tmr == TMR_W'(REQ_TIMEOUT - 1))) begin
                        state  <= BE_ACK;
                        data_q <= dir_send ? ram_q : scsi_din;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                BE_ACK: state <= BE_REL;
                BE_REL: begin
                    if (last_byte) begin
                        state <= BE_IDLE;
                        pos   <= '0;
                    end else begin
                        state <= BE_FETCH;
                        pos   <= pos + POS_W'(1);
                    end
                end
                default: state <= BE_IDLE;
            endcase
        end
    end

    always_comb begin
        busy          = (state != BE_IDLE);
        scsi_ack      = (state == BE_ACK);
        scsi_dout     = data_q;
        blk_done      = (state == BE_REL) && last_byte;
        ram_req.we    = (state == BE_ACK) && !dir_send;
        ram_req.addr  = pos[ADDR_W-1:0];
        ram_req.wdata = data_q;
    end
endmodule

// File: rtl/pdma_buf.sv
module pdma_buf
    import pdma_pkg::*;
#(
    parameter int unsigned REQ_TIMEOUT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_send,
    input  logic              start_recv,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              eop_irq_en,
    input  logic              busy_mon_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              scsi_req,
    input  logic              scsi_bsy,
    input  logic [DATA_W-1:0] scsi_din,
    output logic              scsi_ack,
    output logic [DATA_W-1:0] scsi_dout,
    output logic              ready,
    output logic              loaded,
    output logic              end_of_dma,
    output logic              last_byte_sent,
    output logic              irq,
    output logic              dma_active
);
    xfer_mode_e       mode;
    logic [POS_W-1:0] host_pos;
    logic [POS_W-1:0] blk_len;
    logic [CNT_W-1:0] blk_cnt;
    logic             ready_q, loaded_q, eod_q, lbs_q, irq_q, rd_ok_q;

    logic             wr_ok, rd_ok, cancel, start_ok, eng_go;
    logic             eng_busy, eng_done;
    ram_req_t         eng_req, host_req, ram_req;
    logic [DATA_W-1:0] ram_q;

    assign start_ok = (start_send || start_recv) && (xfer_len != '0);
    assign wr_ok    = host_wr && (mode == XM_SEND) && (host_pos < blk_len);
    assign rd_ok    = host_rd && (mode == XM_RECV) && (host_pos < blk_len);
    assign cancel   = busy_mon_en && !scsi_bsy && (mode != XM_IDLE);
    assign eng_go   = (mode != XM_IDLE) && ready_q && loaded_q &&
                      (host_pos == blk_len) && !eng_busy && !cancel && !start_ok;

    always_comb begin
        host_req.we    = wr_ok;
        host_req.addr  = host_pos[ADDR_W-1:0];
        host_req.wdata = host_wdata;
        ram_req        = eng_busy ? eng_req : host_req;
    end

    pdma_ram u_ram (
        .clk (clk),
        .req (ram_req),
        .q   (ram_q)
    );

    pdma_bus_eng #(.REQ_TIMEOUT(REQ_TIMEOUT)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .abort     (cancel || start_ok),
        .go        (eng_go),
        .dir_send  (mode == XM_SEND),
        .blk_len   (blk_len),
        .scsi_req  (scsi_req),
        .scsi_din  (scsi_din),
        .ram_q     (ram_q),
        .ram_req   (eng_req),
        .busy      (eng_busy),
        .blk_done  (eng_done),
        .scsi_ack  (scsi_ack),
        .scsi_dout (scsi_dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= XM_IDLE;
            host_pos <= '0;
            blk_len  <= '0;
            blk_cnt  <= '0;
            ready_q  <= 1'b0;
            loaded_q <= 1'b0;
            eod_q    <= 1'b0;
            lbs_q    <= 1'b0;
            irq_q    <= 1'b0;
            rd_ok_q  <= 1'b0;
        end else begin
            rd_ok_q <= rd_ok;
            if (start_ok) begin
                mode     <= start_send ? XM_SEND : XM_RECV;
                blk_len  <= calc_blk(xfer_len);
                blk_cnt  <= calc_cnt(xfer_len);
                host_pos <= start_send ? '0 : calc_blk(xfer_len);
                ready_q  <= 1'b1;
                loaded_q <= 1'b1;
                eod_q    <= 1'b0;
                lbs_q    <= 1'b0;
                irq_q    <= 1'b0;
            end else if (cancel) begin
                mode     <= XM_IDLE;
                loaded_q <= 1'b0;
                ready_q  <= 1'b0;
            end else begin
                if (wr_ok || rd_ok) begin
                    host_pos <= host_pos + POS_W'(1);
                    if (host_pos + POS_W'(1) == blk_len) begin
                        ready_q <= 1'b0;
                        if (!loaded_q) mode <= XM_IDLE;
                    end
                end else if (loaded_q && !ready_q && (host_pos == blk_len) &&
                             (blk_cnt != '0)) begin
                    ready_q <= 1'b1;
                end
                if (eng_done) begin
                    host_pos <= '0;
                    blk_cnt  <= blk_cnt - CNT_W'(1);
                    if (blk_cnt == CNT_W'(1)) begin
                        loaded_q <= 1'b0;
                        eod_q    <= 1'b1;
                        lbs_q    <= (mode == XM_SEND);
                        irq_q    <= eop_irq_en;
                        if (mode == XM_SEND) mode <= XM_IDLE;
                    end
                end
            end
        end
    end

    assign host_rdata     = rd_ok_q ? ram_q : '1;
    assign ready          = ready_q;
    assign loaded         = loaded_q;
    assign end_of_dma     = eod_q;
    assign last_byte_sent = lbs_q;
    assign irq            = irq_q;
    assign dma_active     = (mode != XM_IDLE);
endmodule

// File: rtl/pdma_buf_chk.sv
module pdma_buf_chk
    import pdma_pkg::*;
#(
    parameter int unsigned REQ_TIMEOUT = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_send,
    input logic             start_recv,
    input logic [LEN_W-1:0] xfer_len,
    input logic             busy_mon_en,
    input logic             scsi_bsy,
    input logic             scsi_ack,
    input logic             ready,
    input logic             loaded,
    input logic             end_of_dma,
    input logic             last_byte_sent,
    input logic             irq,
    input logic             dma_active,
    input logic             eng_busy
);
    localparam int unsigned GAP_MAX = REQ_TIMEOUT + 2;
    logic [$clog2(GAP_MAX + 2)-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || !eng_busy || scsi_ack) gap <= '0;
        else if (gap <= ($bits(gap))'(GAP_MAX)) gap <= gap + 1'b1;
    end

    // R7: no byte waits more than the REQ timeout plus the fetch/release cycles
    a_r7_req_timeout: assert property (@(posedge clk) disable iff (rst)
        gap <= ($bits(gap))'(GAP_MAX));

    // R6: ACK is a single-cycle pulse
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        scsi_ack |=> !scsi_ack);

    // R6: bus handshake only while a block is loaded
    a_r6_ack_loaded: assert property (@(posedge clk) disable iff (rst)
        $rose(scsi_ack) |-> loaded);

    // R2: a non-empty start arms the transfer
    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        (start_send || start_recv) && (xfer_len != '0)
        |=> ready && loaded && dma_active && !end_of_dma);

    // R2: an empty start is ignored
    a_r2_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start_send || start_recv) && (xfer_len == '0) && !loaded |=> !loaded);

    // R9: completion flags only with end of DMA
    a_r9_irq_eod: assert property (@(posedge clk) disable iff (rst)
        irq |-> end_of_dma);
    a_r9_lbs_eod: assert property (@(posedge clk) disable iff (rst)
        last_byte_sent |-> end_of_dma);

    // R11: BSY loss with monitoring cancels the transfer
    a_r11_bsy_cancel: assert property (@(posedge clk) disable iff (rst)
        busy_mon_en && !scsi_bsy && dma_active && !start_send && !start_recv
        |=> !dma_active && !loaded && !ready);
endmodule

bind pdma_buf pdma_buf_chk #(.REQ_TIMEOUT(REQ_TIMEOUT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_send     (start_send),
    .start_recv     (start_recv),
    .xfer_len       (xfer_len),
    .busy_mon_en    (busy_mon_en),
    .scsi_bsy       (scsi_bsy),
    .scsi_ack       (scsi_ack),
    .ready          (ready),
    .loaded         (loaded),
    .end_of_dma     (end_of_dma),
    .last_byte_sent (last_byte_sent),
    .irq            (irq),
    .dma_active     (dma_active),
    .eng_busy       (eng_busy)
);

// File: tb/pdma_buf_tb.sv
module pdma_buf_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_send, start_recv;
    logic [15:0] xfer_len;
    logic        eop_irq_en, busy_mon_en;
    logic        host_wr, host_rd;
    logic [7:0]  host_wdata, host_rdata;
    logic        scsi_req, scsi_bsy, scsi_ack;
    logic [7:0]  scsi_din, scsi_dout;
    logic        ready, loaded, end_of_dma, last_byte_sent, irq, dma_active;

    int checks = 0;
    int errors = 0;
    int ack_cnt = 0;
    bit bus_chk = 0;
    logic [9:0] rx_idx = '0;
    logic [7:0] rx_arr [1024];
    logic [7:0] bus_q [$];
    logic [7:0] host_q [$];

    always #5 clk = ~clk;

    assign scsi_din = rx_arr[rx_idx];

    pdma_buf u_dut (
        .clk(clk), .rst(rst), .start_send(start_send), .start_recv(start_recv),
        .xfer_len(xfer_len), .eop_irq_en(eop_irq_en), .busy_mon_en(busy_mon_en),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .scsi_req(scsi_req), .scsi_bsy(scsi_bsy),
        .scsi_din(scsi_din), .scsi_ack(scsi_ack), .scsi_dout(scsi_dout),
        .ready(ready), .loaded(loaded), .end_of_dma(end_of_dma),
        .last_byte_sent(last_byte_sent), .irq(irq), .dma_active(dma_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: bus side of the scoreboard
    always @(negedge clk) begin
        if (!rst && scsi_ack) begin
            ack_cnt++;
            rx_idx = rx_idx + 10'd1;
            if (bus_chk) begin
                if (bus_q.size() == 0) chk("R3 unexpected bus byte", 1, 0);
                else chk("R3 bus byte order", int'(scsi_dout), int'(bus_q.pop_front()));
            end
        end
    end

    task automatic host_write(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] b);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        b = host_rdata;
    endtask

    task automatic start(input bit send, input int len);
        xfer_len = 16'(len);
        if (send) start_send = 1'b1; else start_recv = 1'b1;
        @(negedge clk);
        start_send = 1'b0; start_recv = 1'b0;
        ack_cnt = 0;
    endtask

    // driver: pushes expected bytes, then writes them
    task automatic send_bytes(input int n, input int seed, input bit expect_out);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'(seed + i * 7);
            if (expect_out) bus_q.push_back(b);
            host_write(b);
        end
    endtask

    task automatic read_expect(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            host_read(b);
            if (host_q.size() == 0) chk({tag, " no expected byte"}, 1, 0);
            else chk(tag, int'(b), int'(host_q.pop_front()));
        end
    endtask

    task automatic wait_eod(input int lim);
        int k = 0;
        while (!end_of_dma && k < lim) begin @(negedge clk); k++; end
    endtask

    task automatic wait_acks(input int n, input int lim);
        int k = 0;
        while (ack_cnt < n && k < lim) begin @(negedge clk); k++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int k;
        rst = 1'b1; start_send = 0; start_recv = 0; xfer_len = 0;
        eop_irq_en = 0; busy_mon_en = 0; host_wr = 0; host_rd = 0;
        host_wdata = 0; scsi_req = 1; scsi_bsy = 1;
        for (int i = 0; i < 1024; i++) rx_arr[i] = 8'((i * 13 + 5) ^ (i >> 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", ready, 0); chk("R1 loaded", loaded, 0);
        chk("R1 eod", end_of_dma, 0); chk("R1 irq", irq, 0);
        chk("R1 ack", scsi_ack, 0); chk("R1 active", dma_active, 0);
        host_read(b); chk("R1 idle read", b, 8'hFF);

        // R2 zero-length start ignored
        start(1, 0);
        chk("R2 zero len loaded", loaded, 0); chk("R2 zero len active", dma_active, 0);

        // R3/R5/R6/R9 send 8 bytes, REQ high, irq enabled
        eop_irq_en = 1; bus_chk = 1;
        start(1, 8);
        chk("R3 ready at start", ready, 1); chk("R3 loaded at start", loaded, 1);
        send_bytes(8, 17, 1);
        chk("R6 no ack during host phase", ack_cnt, 0);
        chk("R5 ready cleared", ready, 0);
        @(negedge clk);
        chk("R5 ready restored", ready, 1);
        k = 1;
        while (!scsi_ack && k < 100) begin @(negedge clk); k++; end
        chk("R6 first ack delay", k, 4);
        wait_eod(500);
        chk("R2 block size 8", ack_cnt, 8);
        chk("R9 eod", end_of_dma, 1); chk("R9 lbs send", last_byte_sent, 1);
        chk("R9 irq enabled", irq, 1); chk("R9 loaded cleared", loaded, 0);
        chk("R10 send idle", dma_active, 0);
        send_bytes(4, 99, 0);
        repeat (40) @(negedge clk);
        chk("R10 writes after send ignored", ack_cnt, 8);

        // R7 REQ timeout, irq disabled
        eop_irq_en = 0; scsi_req = 0;
        start(1, 4);
        send_bytes(4, 3, 1);
        k = 0;
        while (!scsi_ack && k < 100) begin @(negedge clk); k++; end
        chk("R7 timeout ack delay", k, 13);
        wait_eod(500);
        chk("R7 bytes moved", ack_cnt, 4);
        chk("R9 irq disabled", irq, 0); chk("R9 eod timeout run", end_of_dma, 1);
        scsi_req = 1;

        // R8 two-block send
        start(1, 1024);
        send_bytes(512, 40, 1);
        wait_acks(512, 5000);
        repeat (3) @(negedge clk);
        chk("R8 loaded between blocks", loaded, 1);
        chk("R8 no eod between blocks", end_of_dma, 0);
        chk("R8 no extra acks", ack_cnt, 512);
        send_bytes(512, 41, 1);
        wait_eod(5000);
        chk("R8 two blocks moved", ack_cnt, 1024);
        chk("R8 eod after two", end_of_dma, 1);

        // R2 length 1000 gives one 512 block; R3 extra writes ignored
        start(1, 1000);
        send_bytes(512, 77, 1);
        send_bytes(8, 200, 0);
        wait_eod(5000);
        repeat (20) @(negedge clk);
        chk("R2 length 1000 one block", ack_cnt, 512);
        chk("R3 queue drained", bus_q.size(), 0);

        // R4/R9/R10 receive 16 bytes
        bus_chk = 0; eop_irq_en = 1;
        rx_idx = '0;
        for (int i = 0; i < 16; i++) host_q.push_back(rx_arr[i]);
        start(0, 16);
        host_read(b); chk("R4 early read", b, 8'hFF);
        wait_eod(500);
        chk("R4 bus fill count", ack_cnt, 16);
        chk("R9 lbs not in receive", last_byte_sent, 0);
        chk("R9 irq receive", irq, 1);
        read_expect(16, "R4 receive data");
        host_read(b); chk("R10 read past block", b, 8'hFF);
        chk("R10 receive idle", dma_active, 0);

        // R8 two-block receive
        rx_idx = '0;
        for (int i = 0; i < 1024; i++) host_q.push_back(rx_arr[i]);
        start(0, 1024);
        wait_acks(512, 5000);
        repeat (3) @(negedge clk);
        chk("R8 recv loaded", loaded, 1); chk("R8 recv eod low", end_of_dma, 0);
        read_expect(512, "R8 recv block 1");
        wait_eod(5000);
        chk("R8 recv acks", ack_cnt, 1024);
        read_expect(512, "R8 recv block 2");
        host_read(b); chk("R10 recv drained", b, 8'hFF);

        // R11 BSY cancel
        bus_chk = 1; busy_mon_en = 1;
        start(1, 8);
        send_bytes(3, 1, 0);
        scsi_bsy = 0;
        @(negedge clk);
        chk("R11 active", dma_active, 0); chk("R11 loaded", loaded, 0);
        chk("R11 ready", ready, 0);
        scsi_bsy = 1;
        send_bytes(8, 60, 0);
        repeat (40) @(negedge clk);
        chk("R11 no bus activity", ack_cnt, 0);

        // R11 monitor disabled: BSY low has no effect
        busy_mon_en = 0; scsi_bsy = 0;
        start(1, 4);
        send_bytes(4, 9, 1);
        wait_eod(500);
        chk("R11 unmonitored completes", ack_cnt, 4);
        chk("R11 unmonitored eod", end_of_dma, 1);
        scsi_bsy = 1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule